// File: doc/BRIEF.md
# One's Complement End-Around-Carry Adder/Subtractor

This block adds or subtracts two signed words held in one's complement form, where a negative number is the bitwise inverse of its magnitude. Both all-zeros and all-ones mean zero, so a word of `WIDTH` bits holds the values from -(2^(WIDTH-1)-1) to +(2^(WIDTH-1)-1). The block is purely combinational. It is meant to sit inside a datapath that needs checksum-style or legacy one's complement arithmetic.

A subtract request inverts every bit of the second operand before the addition. The first addition pass produces a partial sum and a carry out of the top bit. When that carry is set, an incrementer adds it back into the lowest bit of the partial sum (the end-around carry). When it is clear, the partial sum is the result. An overflow flag reports a result that the format cannot hold. A parameter selects the structure of the first-pass adder, either a bit-serial carry chain or a parallel-prefix carry tree. Both give identical outputs.

Top module: `oc_eac_addsub`

## Requirements
- R1: With `sub_en` = 0, `op_b` enters the adder unchanged, and when there is no overflow `result` decodes to the signed sum of the two operands (for example 0010 + 0011 = 0101).
- R2: With `sub_en` = 1, every bit of `op_b` is inverted before the addition, so that when there is no overflow `result` decodes to `op_a` minus `op_b`.
- R3: When the first pass carries out of the most significant bit, `result` is the partial sum plus one (for example 0111 - 0001: partial 0101, result 0110). This correction never carries out of the top bit.
- R4: When the first pass produces no carry out, `result` equals the partial sum unchanged (for example 0001 - 0111 = 1001, meaning -6).
- R5: `overflow` is 1 when both effective operands are non-negative (sign bit, the MSB, is 0) and the sign bit of `result` is 1 (for example 0111 + 0111 = 1110 with overflow).
- R6: `overflow` is 1 when both effective operands have sign bit 1 and the sign bit of `result` is 0 (for example 1000 + 1110 at 4 bits, which is -7 + -1).
- R7: `overflow` is 0 whenever `op_a` and the effective second operand have different sign bits.
- R8: Adding an operand to its own bitwise inverse gives all ones (negative zero), with no overflow. The block does not fold negative zero into positive zero.
- R9: The ripple and parallel-prefix settings of `ADDER_KIND` give identical `result` and `overflow` for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand, one's complement |
| op_b | input | WIDTH | Second operand, one's complement |
| sub_en | input | 1 | 1 selects op_a - op_b, 0 selects op_a + op_b |
| result | output | WIDTH | Corrected one's complement result |
| overflow | output | 1 | Result is out of the representable range |

## Verification
The bench applies every operand pair in both directions at 4 bits. It compares each output with a behavioural model built on integer arithmetic modulo 2^N - 1 and on true signed sums.

Several corner cases are targeted. A design that drops the end-around correction is off by one on every carrying subtraction, such as 0111 - 0001. A design that always adds the carry-in corrupts non-carrying results such as 0001 - 0111. A design that judges overflow on the raw operand B, rather than on the inverted one, flags differences of mixed-sign operands falsely. A design that normalises negative zero breaks the all-ones result of x - x.

The two adder variants are also checked against each other. This exposes a wrong prefix tree that a ripple-only run would not reveal.

// File: rtl/oc_pkg.sv
package oc_pkg;

   typedef enum logic [0:0] {
      OC_RIPPLE = 1'b0,
      OC_PREFIX = 1'b1
   } adder_kind_e;

endpackage

// File: rtl/oc_cond_invert.sv
module oc_cond_invert #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] din,
   input  logic             inv,
   output logic [WIDTH-1:0] dout
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign dout[i] = din[i] ^ inv;
   end
endmodule

// File: rtl/oc_first_adder.sv
module oc_first_adder
   import oc_pkg::*;
#(
   parameter int          WIDTH = 8,
   parameter adder_kind_e KIND  = OC_RIPPLE
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

   logic [WIDTH-1:0] gen_b;
   logic [WIDTH-1:0] prp_b;
   logic [WIDTH:0]   carry;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pg
      assign gen_b[i] = x[i] & y[i];
      assign prp_b[i] = x[i] ^ y[i];
   end

   assign carry[0] = 1'b0;

   if (KIND == OC_RIPPLE) begin : g_ripple
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         assign carry[i+1] = gen_b[i] | (prp_b[i] & carry[i]);
      end
   end else begin : g_prefix
      logic [WIDTH-1:0] gg [0:LEVELS];
      logic [WIDTH-1:0] pp [0:LEVELS];
      assign gg[0] = gen_b;
      assign pp[0] = prp_b;
      for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_level
         localparam int DIST = 1 << (lv - 1);
         for (genvar i = 0; i < WIDTH; i++) begin : g_node
            if (i >= DIST) begin : g_merge
               assign gg[lv][i] = gg[lv-1][i] | (pp[lv-1][i] & gg[lv-1][i-DIST]);
               assign pp[lv][i] = pp[lv-1][i] & pp[lv-1][i-DIST];
            end else begin : g_pass
               assign gg[lv][i] = gg[lv-1][i];
               assign pp[lv][i] = pp[lv-1][i];
            end
         end
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_cout
         assign carry[i+1] = gg[LEVELS][i];
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_sum
      assign sum[i] = prp_b[i] ^ carry[i];
   end
   assign cout = carry[WIDTH];
endmodule

// File: rtl/oc_eac_incr.sv
module oc_eac_incr #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] part,
   input  logic             en,
   output logic [WIDTH-1:0] fixed,
   output logic             spill
);
   logic [WIDTH:0] chain;
   assign chain[0] = en;
   for (genvar i = 0; i < WIDTH; i++) begin : g_inc
      assign fixed[i]   = part[i] ^ chain[i];
      assign chain[i+1] = part[i] & chain[i];
   end
   assign spill = chain[WIDTH];
endmodule

// File: rtl/oc_ovf_judge.sv
module oc_ovf_judge #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   input  logic [WIDTH-1:0] res,
   output logic             ovf
);
   localparam int SB = WIDTH - 1;
   logic same_sign;
   assign same_sign = ~(lhs[SB] ^ rhs[SB]);
   assign ovf       = same_sign & (res[SB] ^ lhs[SB]);
endmodule

// File: rtl/oc_eac_addsub.sv
module oc_eac_addsub
   import oc_pkg::*;
#(
   parameter int          WIDTH      = 8,
   parameter adder_kind_e ADDER_KIND = OC_RIPPLE
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             sub_en,
   output logic [WIDTH-1:0] result,
   output logic             overflow
);
   if (WIDTH < 2) begin : g_bad_width
      $error("oc_eac_addsub: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] part_sum;
   logic             part_cout;
   logic             incr_spill;

   oc_cond_invert #(.WIDTH(WIDTH)) u_inv (
      .din (op_b),
      .inv (sub_en),
      .dout(b_eff)
   );

   oc_first_adder #(.WIDTH(WIDTH), .KIND(ADDER_KIND)) u_add (
      .x   (op_a),
      .y   (b_eff),
      .sum (part_sum),
      .cout(part_cout)
   );

   oc_eac_incr #(.WIDTH(WIDTH)) u_eac (
      .part (part_sum),
      .en   (part_cout),
      .fixed(result),
      .spill(incr_spill)
   );

   oc_ovf_judge #(.WIDTH(WIDTH)) u_ovf (
      .lhs(op_a),
      .rhs(b_eff),
      .res(result),
      .ovf(overflow)
   );
endmodule

// File: rtl/oc_eac_addsub_chk.sv
module oc_eac_addsub_chk #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic             sub_en,
   input logic [WIDTH-1:0] b_eff,
   input logic [WIDTH-1:0] part_sum,
   input logic             part_cout,
   input logic             incr_spill,
   input logic [WIDTH-1:0] result,
   input logic             overflow
);
   localparam int SB = WIDTH - 1;

   always_comb begin
      AST_NO_SECOND_CARRY: assert (!incr_spill); // R3
      if (part_cout) begin
         AST_EAC_PLUS_ONE: assert (result == part_sum + 1'b1); // R3
      end else begin
         AST_NO_CARRY_PASS: assert (result == part_sum); // R4
      end
      if (op_a[SB] != b_eff[SB]) begin
         AST_MIXED_NO_OVF: assert (!overflow); // R7
      end
      if (b_eff == ~op_a) begin
         AST_NEG_ZERO: assert (&result && !overflow); // R8
      end
   end
endmodule

bind oc_eac_addsub oc_eac_addsub_chk #(.WIDTH(WIDTH)) u_chk (
   .op_a      (op_a),
   .op_b      (op_b),
   .sub_en    (sub_en),
   .b_eff     (b_eff),
   .part_sum  (part_sum),
   .part_cout (part_cout),
   .incr_spill(incr_spill),
   .result    (result),
   .overflow  (overflow)
);

// File: tb/test_oc_eac_addsub.sv
module test_oc_eac_addsub;
   import oc_pkg::*;

   localparam int W    = 4;
   localparam int MASK = (1 << W) - 1;
   localparam int MAXV = (1 << (W - 1)) - 1;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [W-1:0] a, b;
   logic         sub;
   logic [W-1:0] res_r, res_p;
   logic         ovf_r, ovf_p;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   oc_eac_addsub #(.WIDTH(W), .ADDER_KIND(OC_RIPPLE)) i_oc_eac_addsub (
      .op_a(a), .op_b(b), .sub_en(sub), .result(res_r), .overflow(ovf_r));

   oc_eac_addsub #(.WIDTH(W), .ADDER_KIND(OC_PREFIX)) i_oc_eac_addsub_pfx (
      .op_a(a), .op_b(b), .sub_en(sub), .result(res_p), .overflow(ovf_p));

   function automatic int decode(int x);
      return ((x >> (W - 1)) & 1) ? -((~x) & MASK) : x;
   endfunction

   task automatic check(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s a=%0h b=%0h sub=%0d actual=%0h expected=%0h",
                  tag, a, b, sub, act, exp);
      end
   endtask

   task automatic apply(int va, int vb, bit vs);
      @(posedge clk);
      a   = W'(va);
      b   = W'(vb);
      sub = vs;
      @(negedge clk);
   endtask

   task automatic model_check();
      int beff, t, exp_res, sum;
      bit exp_ovf;
      beff    = sub ? ((~int'(b)) & MASK) : int'(b);
      t       = int'(a) + beff;
      exp_res = (t > MASK) ? (t - MASK - 1 + 1) : t;
      sum     = decode(int'(a)) + (sub ? -decode(int'(b)) : decode(int'(b)));
      exp_ovf = (sum > MAXV) || (sum < -MAXV);
      if (t > MASK) check("R3 end-around result", int'(res_r), exp_res);
      else          check("R4 no-carry result", int'(res_r), exp_res);
      if (exp_ovf && sum > 0)      check("R5 positive overflow", int'(ovf_r), 1);
      else if (exp_ovf)            check("R6 negative overflow", int'(ovf_r), 1);
      else if (a[W-1] != beff[W-1]) check("R7 mixed signs no overflow", int'(ovf_r), 0);
      else                         check("R5 R6 no overflow", int'(ovf_r), 0);
      if (!exp_ovf) begin
         if (sub) check("R2 difference value", decode(int'(res_r)), sum);
         else     check("R1 sum value", decode(int'(res_r)), sum);
      end
      if (beff == ((~int'(a)) & MASK)) check("R8 negative zero", int'(res_r), MASK);
      check("R9 variants agree result", int'(res_p), int'(res_r));
      check("R9 variants agree overflow", int'(ovf_p), int'(ovf_r));
   endtask

   initial begin
      a = '0; b = '0; sub = 1'b0;
      @(negedge clk);
      check("R1 initial zero result", int'(res_r), 0);
      check("R1 initial no overflow", int'(ovf_r), 0);

      apply(4'b0010, 4'b0011, 1'b0); check("R1 2+3", int'(res_r), 4'b0101);
      apply(4'b0111, 4'b0001, 1'b1); check("R3 7-1", int'(res_r), 4'b0110);
      apply(4'b0001, 4'b0111, 1'b1); check("R4 1-7", int'(res_r), 4'b1001);
      apply(4'b0111, 4'b0111, 1'b0); check("R5 7+7 result", int'(res_r), 4'b1110);
      check("R5 7+7 flag", int'(ovf_r), 1);
      apply(4'b1000, 4'b1110, 1'b0); check("R6 -7+-1 flag", int'(ovf_r), 1);
      apply(4'b0101, 4'b0101, 1'b1); check("R8 5-5", int'(res_r), 4'b1111);
      apply(4'b0011, 4'b0100, 1'b1); check("R7 3-4 flag", int'(ovf_r), 0);

      for (int s = 0; s < 2; s++) begin
         for (int i = 0; i <= MASK; i++) begin
            for (int j = 0; j <= MASK; j++) begin
               apply(i, j, bit'(s));
               model_check();
            end
         end
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule